// File: doc/BRIEF.md
# Multi-Address I2C Target Address Matcher

This block decides whether an I2C target answers the address byte that a separate bit-level protocol engine has just shifted in. The engine presents the full byte together with a one-cycle strobe. The block compares bits 7:1 of that byte against five candidates. One is a device address fixed by a parameter. Three are programmable subaddresses. The last is a programmable all-call address. Each programmable address has its own enable bit.

One clock after the strobe, the block returns an acknowledge decision, the read/write flag taken from bit 0 of the byte, a vector with every candidate that matched, and a code naming the highest-priority match. A small register port lets the surrounding logic read and write the four programmable addresses and the enable bits. The address registers store only bits 7:1, and bit 0 always reads as zero.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, select 0, 1, 2 and 3 read E2h, E4h, E8h and E0h. Select 4 reads 01h. In the select-4 enable byte, bit 0 enables all-call and bits 1, 2 and 3 enable subaddresses 1, 2 and 3.
- R2: Bit 0 of every address register (selects 0 to 3) reads 0 whatever was written to it. Bits 7:1 keep the written value.
- R3: A write with `reg_wr` high takes effect at the next clock edge. Selects 0 to 3 are subaddress 1, subaddress 2, subaddress 3 and all-call. Select 4 is the enable byte, and only its bits 3:0 are stored. Selects 5 to 7 read 00h and writes to them change nothing.
- R4: An address byte whose bits 7:1 equal `DEV_ADDR` (default 40h, byte 80h/81h) is always acknowledged, and it sets hit bit 0.
- R5: A programmable address is acknowledged only while its enable bit is 1. A disabled match leaves its hit bit 0.
- R6: `rw_o` equals bit 0 of the strobed byte. A matching address is acknowledged for both values of that bit.
- R7: `hit_o` shows every matching source at once: bit 0 device, bit 1 all-call, bits 2, 3 and 4 subaddress 1, 2 and 3.
- R8: `src_o` names the highest-priority match, in this order: device (1), all-call (2), subaddress 1 (3), subaddress 2 (4), subaddress 3 (5). It is 0 when nothing matches, and `ack_o` is 1 exactly when `src_o` is nonzero.
- R9: `valid_o` is high for exactly the one cycle after each strobe. `ack_o`, `rw_o`, `hit_o` and `src_o` change only in that cycle and then hold their values.
- R10: When a strobe and a register write fall in the same cycle, the decision uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | One-cycle strobe: `addr_byte` holds a received address byte |
| addr_byte | input | 8 | Received byte: bits 7:1 are the address, bit 0 is the read/write flag |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| valid_o | output | 1 | Decision is new this cycle |
| ack_o | output | 1 | Acknowledge decision |
| rw_o | output | 1 | Read/write flag of the decided byte |
| hit_o | output | 5 | All matching sources |
| src_o | output | 3 | Highest-priority matching source code |

## Verification
Two functions can fall in the same cycle: an address strobe and a register write that changes the candidate it is compared against. The bench provokes this by strobing byte E2h while subaddress 1 is disabled, and in the same cycle writing the enable byte to turn subaddress 1 on. That decision must refuse the byte. A second strobe of E2h must then be acknowledged with source code 3. A similar collision happens inside the compare itself: several sources can match one byte. Programmed duplicates of the device and all-call addresses are judged on the full hit vector and on the priority code.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;
    localparam int ADDR_W = 7;
    localparam int NPROG  = 4;            // programmable slots: sub1, sub2, sub3, all-call
    localparam int NHIT   = 5;            // device + programmable
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_SUB1 = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SUB2 = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SUB3 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ALLC = 3'd3;
    localparam logic [SEL_W-1:0] SEL_EN   = 3'd4;

    // slot index in the programmable array
    localparam int SLOT_SUB1 = 0;
    localparam int SLOT_SUB2 = 1;
    localparam int SLOT_SUB3 = 2;
    localparam int SLOT_ALLC = 3;

    localparam logic [NPROG-1:0][ADDR_W-1:0] ADDR_RST = {7'h70, 7'h74, 7'h72, 7'h71};
    localparam logic [NPROG-1:0]             EN_RST   = 4'b0001;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_DEV  = 3'd1,
        SRC_ALLC = 3'd2,
        SRC_SUB1 = 3'd3,
        SRC_SUB2 = 3'd4,
        SRC_SUB3 = 3'd5
    } src_e;

    typedef struct packed {
        logic [NPROG-1:0][ADDR_W-1:0] addr;
        logic [NPROG-1:0]             en;    // bit0 all-call, bits 1..3 sub1..sub3
    } cfg_t;

    typedef struct packed {
        logic            valid;
        logic            ack;
        logic            rw;
        logic [NHIT-1:0] hits;
        src_e            src;
    } dec_t;
endpackage

// File: rtl/i2c_addr_regfile.sv
module i2c_addr_regfile
    import i2c_addr_match_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [SEL_W-1:0]              reg_sel,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    output logic [NPROG-1:0][ADDR_W-1:0]  addr_o,
    output logic [NPROG-1:0]              en_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            if (reg_sel < SEL_EN) begin
                cfg_d.addr[reg_sel[1:0]] = reg_wdata[7:1];
            end else if (reg_sel == SEL_EN) begin
                cfg_d.en = reg_wdata[NPROG-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.addr <= ADDR_RST;
            cfg_q.en   <= EN_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_sel < SEL_EN) begin
            reg_rdata = {cfg_q.addr[reg_sel[1:0]], 1'b0};
        end else if (reg_sel == SEL_EN) begin
            reg_rdata = {{(8-NPROG){1'b0}}, cfg_q.en};
        end
    end

    assign addr_o = cfg_q.addr;
    assign en_o   = cfg_q.en;

    // R1
    rst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q.en == EN_RST && cfg_q.addr == ADDR_RST));

    // R2
    lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel < SEL_EN) |-> (reg_rdata[0] == 1'b0));

    // R3
    wr_sub1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_SUB1) |=> (addr_o[SLOT_SUB1] == $past(reg_wdata[7:1])));
endmodule

// File: rtl/i2c_addr_compare.sv
module i2c_addr_compare
    import i2c_addr_match_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
) (
    input  logic [ADDR_W-1:0]             rx_addr,
    input  logic [NPROG-1:0][ADDR_W-1:0]  addr_i,
    input  logic [NPROG-1:0]              en_i,
    output logic [NHIT-1:0]               hits_o,
    output src_e                          src_o
);
    logic [NHIT-1:0] hit_w;

    assign hit_w[0] = (rx_addr == DEV_ADDR);
    assign hit_w[1] = en_i[0] && (rx_addr == addr_i[SLOT_ALLC]);

    genvar g;
    generate
        for (g = 0; g < NPROG - 1; g++) begin : g_sub
            assign hit_w[2+g] = en_i[1+g] && (rx_addr == addr_i[g]);
        end
    endgenerate

    // hit bit order equals priority order: lowest set bit wins
    always_comb begin
        src_o = SRC_NONE;
        for (int i = NHIT - 1; i >= 0; i--) begin
            if (hit_w[i]) src_o = src_e'(3'(i + 1));
        end
    end

    assign hits_o = hit_w;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_addr_match_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_stb,
    input  logic [7:0]       addr_byte,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             valid_o,
    output logic             ack_o,
    output logic             rw_o,
    output logic [4:0]       hit_o,
    output logic [2:0]       src_o
);
    logic [NPROG-1:0][ADDR_W-1:0] addr_w;
    logic [NPROG-1:0]             en_w;
    logic [NHIT-1:0]              hits_w;
    src_e                         src_w;
    dec_t                         dec_d, dec_q;

    i2c_addr_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .addr_o    (addr_w),
        .en_o      (en_w)
    );

    i2c_addr_compare #(.DEV_ADDR(DEV_ADDR)) u_cmp (
        .rx_addr (addr_byte[7:1]),
        .addr_i  (addr_w),
        .en_i    (en_w),
        .hits_o  (hits_w),
        .src_o   (src_w)
    );

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = addr_stb;
        if (addr_stb) begin
            dec_d.ack  = (src_w != SRC_NONE);
            dec_d.rw   = addr_byte[0];
            dec_d.hits = hits_w;
            dec_d.src  = src_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '{valid: 1'b0, ack: 1'b0, rw: 1'b0, hits: '0, src: SRC_NONE};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign valid_o = dec_q.valid;
    assign ack_o   = dec_q.ack;
    assign rw_o    = dec_q.rw;
    assign hit_o   = dec_q.hits;
    assign src_o   = dec_q.src;

    // R4
    dev_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && hit_o[0]) |-> ($past(addr_byte[7:1]) == DEV_ADDR));

    // R5
    sub1_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && hit_o[2]) |-> $past(en_w[1]));

    // R8
    dev_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && hit_o[0]) |-> (src_o == SRC_DEV));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !$past(!rst_n)) |-> $stable(src_o));
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_stb = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       valid_o, ack_o, rw_o;
    logic [4:0] hit_o;
    logic [2:0] src_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    i2c_addr_match dut_i (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_byte(addr_byte),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .valid_o(valid_o), .ack_o(ack_o), .rw_o(rw_o), .hit_o(hit_o), .src_o(src_o)
    );

    // {byte[16:9], ack[8], src[7:5], hits[4:0]} after setup:
    // en=0F, sub1=E2, sub2=80, sub3=E0, all-call=E0
    localparam logic [16:0] VEC [10] = '{
        {8'hE2, 1'b1, 3'd3, 5'b00100},
        {8'hE3, 1'b1, 3'd3, 5'b00100},
        {8'h80, 1'b1, 3'd1, 5'b01001},
        {8'h81, 1'b1, 3'd1, 5'b01001},
        {8'hE0, 1'b1, 3'd2, 5'b10010},
        {8'hE1, 1'b1, 3'd2, 5'b10010},
        {8'hE4, 1'b0, 3'd0, 5'b00000},
        {8'hE8, 1'b0, 3'd0, 5'b00000},
        {8'h00, 1'b0, 3'd0, 5'b00000},
        {8'hFE, 1'b0, 3'd0, 5'b00000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        check(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic strobe_check(input string req, input logic [7:0] b, input logic ack,
                                input logic [2:0] src, input logic [4:0] hits);
        @(negedge clk);
        addr_stb = 1'b1; addr_byte = b;
        @(negedge clk);
        addr_stb = 1'b0;
        check({req, " valid"}, {31'h0, valid_o}, 32'h1);
        check({req, " ack"}, {31'h0, ack_o}, {31'h0, ack});
        check({req, " rw"}, {31'h0, rw_o}, {31'h0, b[0]});
        check({req, " src"}, {29'h0, src_o}, {29'h0, src});
        check({req, " hits"}, {27'h0, hit_o}, {27'h0, hits});
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset defaults, R3 unused selects
        check("R9 valid idle", {31'h0, valid_o}, 32'h0);
        rd_check("R1 sub1", 3'd0, 8'hE2);
        rd_check("R1 sub2", 3'd1, 8'hE4);
        rd_check("R1 sub3", 3'd2, 8'hE8);
        rd_check("R1 allcall", 3'd3, 8'hE0);
        rd_check("R1 enable", 3'd4, 8'h01);
        rd_check("R3 sel5", 3'd5, 8'h00);
        // R5 subaddress disabled after reset; R4 device; R6 read flag
        strobe_check("R5 sub1 off", 8'hE2, 1'b0, 3'd0, 5'b00000);
        strobe_check("R6 allcall read", 8'hE1, 1'b1, 3'd2, 5'b00010);
        strobe_check("R4 device", 8'h80, 1'b1, 3'd1, 5'b00001);
        // R9 outputs hold after the pulse
        @(negedge clk);
        check("R9 hold valid", {31'h0, valid_o}, 32'h0);
        check("R9 hold src", {29'h0, src_o}, 32'h1);
        // setup; R2 LSB dropped
        wr_reg(3'd4, 8'h0F);
        wr_reg(3'd1, 8'h81);
        rd_check("R2 lsb", 3'd1, 8'h80);
        wr_reg(3'd2, 8'hE1);
        rd_check("R2 lsb sub3", 3'd2, 8'hE0);
        rd_check("R3 enable", 3'd4, 8'h0F);
        // R7 R8 vector walk
        for (int i = 0; i < 10; i++) begin
            strobe_check("R7 R8 vec", VEC[i][16:9], VEC[i][8], VEC[i][7:5], VEC[i][4:0]);
        end
        // R5 all-call disabled, only sub3 on
        wr_reg(3'd4, 8'h08);
        strobe_check("R5 allcall off", 8'hE0, 1'b1, 3'd5, 5'b10000);
        strobe_check("R5 sub1 off again", 8'hE2, 1'b0, 3'd0, 5'b00000);
        // R3 writes to unused select are ignored
        wr_reg(3'd6, 8'hFF);
        rd_check("R3 sel6", 3'd6, 8'h00);
        rd_check("R3 enable kept", 3'd4, 8'h08);
        rd_check("R3 sub1 kept", 3'd0, 8'hE2);
        // R10 strobe and write in the same cycle
        @(negedge clk);
        addr_stb = 1'b1; addr_byte = 8'hE2;
        reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h02;
        @(negedge clk);
        addr_stb = 1'b0; reg_wr = 1'b0;
        check("R10 old enable ack", {31'h0, ack_o}, 32'h0);
        check("R10 old enable src", {29'h0, src_o}, 32'h0);
        strobe_check("R10 new enable", 8'hE2, 1'b1, 3'd3, 5'b00100);
        // R1 reset restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1 re-reset sub2", 3'd1, 8'hE4);
        rd_check("R1 re-reset enable", 3'd4, 8'h01);
        check("R1 re-reset ack", {31'h0, ack_o}, 32'h0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule